// File: doc/BRIEF.md
# GPIO Interrupt Detector Bank

A bank of per-pin interrupt detectors for a general-purpose I/O controller. Every pin input is brought into the clock domain by a two-flop synchronizer. A detector then looks for a rising edge, a falling edge, both edges, or an active level, as the pin's configuration selects. A detected event sets a sticky pending flag. Software clears the flag with an acknowledge write. The value that counts as an acknowledge is fixed when the block is built.

Each pin also has a three-bit routing field. The single summary interrupt to the parent controller is a registered OR over all pins. A pin contributes to it only when its flag is pending, its enable bit is set and its routing field holds the application-processor code. The detection field is one or two bits wide, chosen by a build parameter, and each width has its own encoding. Software reaches all per-pin state through a plain write/read register port. Reads are combinational from the address.

Address layout: `addr = {pin, sel}`, with `sel` in the low two bits. Sel 0 is configuration, sel 1 is status and sel 2 is routing. Sel 3 reads zero and ignores writes. The configuration word holds:

| Bit(s) | Field |
|---|---|
| 0 | enable |
| 1 | raw-status enable |
| 2 | polarity |
| 3 and up | detection field, one or two bits |

The status word holds:

| Bit | Field |
|---|---|
| 0 | pending flag |
| 1 | synchronized pin level |

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin's configuration reads 0xE (disabled, raw-status enabled, polarity 1, detection code 1). Status bit 0 reads 0, routing reads 0, and the summary output is low.
- R2: With a 2-bit detection field, code 01 latches on rising edges, 10 on falling edges and 11 on both edges. The polarity bit has no effect on which edges latch.
- R3: With detection code 0 the pin is level sensitive: polarity 1 means active high and 0 means active low. While the active level persists the flag is set again every clock, so an acknowledge has no lasting effect.
- R4: With a 1-bit detection field, a 1 selects edge detection with polarity 1 = rising and 0 = falling, and a 0 selects level detection.
- R5: A flag set by an edge stays set after the pin returns to its former level, until it is acknowledged.
- R6: A write to the status word clears the flag only when data bit 0 equals the build's acknowledge value. A write of the other value leaves the flag unchanged.
- R7: If an acknowledge and a new event for the same pin fall in the same cycle, the flag stays set.
- R8: While raw-status enable is 0 no event latches. Setting the bit again does not by itself latch a flag.
- R9: The summary output is high one clock after some pin has its flag set, its enable set and routing equal to 4. It drops one clock after the last such condition goes away.
- R10: Status bit 1 reads the synchronized pin level, independent of the flag.
- R11: An edge on a pin sets the flag on the third rising clock edge after the pin changes (two synchronizer stages, then the flag register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | {pin, sel} register address |
| wrData | input | CFG_W | Write data |
| rdData | output | CFG_W | Read data for addr |
| pinIn | input | NUM_PINS | Asynchronous pin inputs |
| irqOut | output | 1 | Summary interrupt to the parent controller |

## Verification
The hardest case to reach is an acknowledge that lands in the same clock as a fresh edge on the same pin. The stimulus reaches it by counting synchronizer stages: it changes the pin just after a falling clock edge, then holds the status write so that the write is sampled on exactly the third rising edge. The same timing, without a write, also pins down the latency. A second instance, built with a 1-bit detection field and acknowledge-by-zero, is swept alongside the main one. This covers both encodings and both acknowledge senses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_STS  = 2'd1,
    SEL_TGT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic ackWr;
    logic tgtWr;
  } strobe_t;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_RAW_BIT = 1;
  localparam int CFG_POL_BIT = 2;
  localparam int CFG_DET_LSB = 3;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter bit ACK_HIGH = 1'b1,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                wrEn,
  input  logic [PIN_W+1:0]    addr,
  input  logic                ackBit,
  output strobe_t             strobe,
  output logic [NUM_PINS-1:0] pinSel
);
  reg_sel_e         sel;
  logic [PIN_W-1:0] pinIdx;

  always_comb begin
    sel    = reg_sel_e'(addr[1:0]);
    pinIdx = addr[PIN_W+1:2];
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
    assign pinSel[i] = (pinIdx == PIN_W'(i));
  end

  always_comb begin
    strobe       = '0;
    strobe.cfgWr = wrEn && (sel == SEL_CFG);
    strobe.tgtWr = wrEn && (sel == SEL_TGT);
    strobe.ackWr = wrEn && (sel == SEL_STS) && (ackBit == ACK_HIGH);
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int         NUM_PINS    = 4,
  parameter int         DET_WIDTH   = 2,
  parameter int         TGT_W       = 3,
  parameter logic [2:0] APPS_TARGET = 3'd4,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int CFG_W = CFG_DET_LSB + DET_WIDTH
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [NUM_PINS-1:0] pinSel,
  input  logic [CFG_W-1:0]    wrData,
  input  logic [PIN_W-1:0]    rdPin,
  input  logic [1:0]          rdSel,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [CFG_W-1:0]    rdData,
  output logic                irqOut
);
  logic [NUM_PINS-1:0] syncA, lvlV, prvV;
  logic [NUM_PINS-1:0] enV, rawV, polV, stsV, evtV, contribV;
  logic [DET_WIDTH-1:0] detA [NUM_PINS];
  logic [TGT_W-1:0]     tgtA [NUM_PINS];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic riseD, fallD, hitD;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[i] <= 1'b0;
        lvlV[i]  <= 1'b0;
        prvV[i]  <= 1'b0;
      end else begin
        syncA[i] <= pinIn[i];
        lvlV[i]  <= syncA[i];
        prvV[i]  <= lvlV[i];
      end
    end

    assign riseD = lvlV[i] & ~prvV[i];
    assign fallD = ~lvlV[i] & prvV[i];

    if (DET_WIDTH == 2) begin : g_w2
      always_comb begin
        case (detA[i])
          2'd1:    hitD = riseD;
          2'd2:    hitD = fallD;
          2'd3:    hitD = riseD | fallD;
          default: hitD = (lvlV[i] == polV[i]);
        endcase
      end
    end else begin : g_w1
      always_comb begin
        if (detA[i][0]) hitD = polV[i] ? riseD : fallD;
        else            hitD = (lvlV[i] == polV[i]);
      end
    end

    assign evtV[i] = rawV[i] & hitD;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enV[i]  <= 1'b0;
        rawV[i] <= 1'b1;
        polV[i] <= 1'b1;
        detA[i] <= DET_WIDTH'(1);
        tgtA[i] <= '0;
      end else begin
        if (strobe.cfgWr && pinSel[i]) begin
          enV[i]  <= wrData[CFG_EN_BIT];
          rawV[i] <= wrData[CFG_RAW_BIT];
          polV[i] <= wrData[CFG_POL_BIT];
          detA[i] <= wrData[CFG_DET_LSB +: DET_WIDTH];
        end
        if (strobe.tgtWr && pinSel[i]) tgtA[i] <= wrData[TGT_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              stsV[i] <= 1'b0;
      else if (evtV[i])                       stsV[i] <= 1'b1;
      else if (strobe.ackWr && pinSel[i])     stsV[i] <= 1'b0;
    end

    assign contribV[i] = stsV[i] & enV[i] & (tgtA[i] == APPS_TARGET[TGT_W-1:0]);

    // R8
    raw_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stsV[i]) |-> $past(rawV[i]));
    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rawV[i] && detA[i] == '0 && lvlV[i] == polV[i]) |=> stsV[i]);
    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.ackWr && pinSel[i] && !evtV[i]) |=> !stsV[i]);
    // R7
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtV[i] |=> stsV[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |contribV;
  end

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|(stsV & enV)));

  always_comb begin
    rdData = '0;
    case (reg_sel_e'(rdSel))
      SEL_CFG: begin
        rdData[CFG_EN_BIT]  = enV[rdPin];
        rdData[CFG_RAW_BIT] = rawV[rdPin];
        rdData[CFG_POL_BIT] = polV[rdPin];
        rdData[CFG_DET_LSB +: DET_WIDTH] = detA[rdPin];
      end
      SEL_STS: begin
        rdData[0] = stsV[rdPin];
        rdData[1] = lvlV[rdPin];
      end
      SEL_TGT:  rdData[TGT_W-1:0] = tgtA[rdPin];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int         NUM_PINS    = 4,
  parameter int         DET_WIDTH   = 2,
  parameter bit         ACK_HIGH    = 1'b1,
  parameter int         TGT_W       = 3,
  parameter logic [2:0] APPS_TARGET = 3'd4,
  localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W = PIN_W + 2,
  localparam int CFG_W  = CFG_DET_LSB + DET_WIDTH
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CFG_W-1:0]    wrData,
  output logic [CFG_W-1:0]    rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                irqOut
);
  strobe_t             strobe;
  logic [NUM_PINS-1:0] pinSel;

  gpio_irq_ctrl #(.NUM_PINS(NUM_PINS), .ACK_HIGH(ACK_HIGH)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .ackBit(wrData[0]),
    .strobe(strobe), .pinSel(pinSel)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS), .DET_WIDTH(DET_WIDTH), .TGT_W(TGT_W),
                .APPS_TARGET(APPS_TARGET)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pinSel(pinSel),
    .wrData(wrData), .rdPin(addr[ADDR_W-1:2]), .rdSel(addr[1:0]),
    .pinIn(pinIn), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn0 = 1'b0, wrEn1 = 1'b0;
  logic [3:0] addr = '0;
  logic [4:0] wrData = '0;
  logic [3:0] pinIn = '0;
  logic [4:0] rd0;
  logic [3:0] rd1;
  logic       irq0, irq1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.DET_WIDTH(2), .ACK_HIGH(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn0), .addr(addr), .wrData(wrData),
    .rdData(rd0), .pinIn(pinIn), .irqOut(irq0));

  gpio_irq_bank #(.DET_WIDTH(1), .ACK_HIGH(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn1), .addr(addr), .wrData(wrData[3:0]),
    .rdData(rd1), .pinIn(pinIn), .irqOut(irq1));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input int k, input int p, input int sel, input int data);
    @(negedge clk);
    addr = {2'(p), 2'(sel)};
    wrData = 5'(data);
    if (k == 0) wrEn0 = 1'b1; else wrEn1 = 1'b1;
    @(negedge clk);
    wrEn0 = 1'b0; wrEn1 = 1'b0;
  endtask

  task automatic rd(input int k, input int p, input int sel, output int v);
    addr = {2'(p), 2'(sel)};
    #1;
    v = (k == 0) ? int'(rd0) : int'(rd1);
  endtask

  task automatic ack(input int k, input int p);
    wr(k, p, 1, (k == 0) ? 1 : 0);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int hitOf(input int k, input int d, input int q, input int rise);
    if (k == 0) begin
      case (d)
        1: return rise;
        2: return 1 - rise;
        3: return 1;
        default: return 0;
      endcase
    end
    if (d == 1) return (q == 1) ? rise : 1 - rise;
    return 0;
  endfunction

  initial begin
    int v;
    string tag;
    waitc(3);
    rstN = 1'b1;
    waitc(2);
    // R1 reset state
    for (int p = 0; p < 4; p++) begin
      rd(0, p, 0, v); chk("R1 cfg u0", v, 14);
      rd(1, p, 0, v); chk("R1 cfg u1", v, 14);
      rd(0, p, 1, v); chk("R1 sts", v & 1, 0);
      rd(0, p, 2, v); chk("R1 tgt", v, 0);
    end
    chk("R1 irq0", int'(irq0), 0);
    chk("R1 irq1", int'(irq1), 0);

    // sweep of modes, polarities and pins on both builds (R2 R3 R4 R10)
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < 4; p++)
        for (int d = 0; d < ((k == 0) ? 4 : 2); d++)
          for (int q = 0; q < 2; q++) begin
            int lvl;
            lvl = (d == 0);
            if (k == 1) tag = "R4";
            else if (lvl != 0) tag = "R3";
            else tag = "R2";
            pinIn = '0;
            waitc(4);
            wr(k, p, 0, (d << 3) | (q << 2) | 3);
            ack(k, p); waitc(2);
            rd(k, p, 1, v); chk({tag, " idle-low"}, v & 1, int'(lvl != 0 && q == 0));
            pinIn[p] = 1'b1; waitc(5);
            rd(k, p, 1, v);
            chk({tag, " rise"}, v & 1, (lvl != 0) ? 1 : hitOf(k, d, q, 1));
            chk("R10 level high", (v >> 1) & 1, 1);
            ack(k, p); waitc(2);
            rd(k, p, 1, v); chk({tag, " after ack high"}, v & 1, int'(lvl != 0 && q == 1));
            pinIn[p] = 1'b0; waitc(5);
            rd(k, p, 1, v);
            chk({tag, " fall"}, v & 1, (lvl != 0) ? 1 : hitOf(k, d, q, 0));
            chk("R10 level low", (v >> 1) & 1, 0);
            ack(k, p);
          end

    // R5 sticky, R6 acknowledge value (u0 clears on 1)
    wr(0, 0, 0, 15); ack(0, 0); waitc(2);
    pinIn[0] = 1'b1; waitc(5); pinIn[0] = 1'b0; waitc(5);
    rd(0, 0, 1, v); chk("R5 sticky u0", v & 1, 1);
    wr(0, 0, 1, 0); rd(0, 0, 1, v); chk("R6 write0 no clear u0", v & 1, 1);
    wr(0, 0, 1, 1); rd(0, 0, 1, v); chk("R6 write1 clears u0", v & 1, 0);
    // R6 on u1 (clears on 0), falling-edge mode
    wr(1, 0, 0, 11); ack(1, 0); waitc(2);
    pinIn[0] = 1'b1; waitc(5); pinIn[0] = 1'b0; waitc(5);
    rd(1, 0, 1, v); chk("R5 sticky u1", v & 1, 1);
    wr(1, 0, 1, 1); rd(1, 0, 1, v); chk("R6 write1 no clear u1", v & 1, 1);
    wr(1, 0, 1, 0); rd(1, 0, 1, v); chk("R6 write0 clears u1", v & 1, 0);

    // R9 summary gating and one-cycle latency
    wr(0, 0, 0, 15); ack(0, 0); wr(0, 0, 2, 4); waitc(1);
    chk("R9 no pending", int'(irq0), 0);
    pinIn[0] = 1'b1; waitc(5);
    chk("R9 routed and enabled", int'(irq0), 1);
    wr(0, 0, 2, 2);
    chk("R9 registered latency", int'(irq0), 1);
    waitc(1); chk("R9 other target", int'(irq0), 0);
    wr(0, 0, 2, 4); waitc(1); chk("R9 target back", int'(irq0), 1);
    wr(0, 0, 0, 14); waitc(1); chk("R9 disabled", int'(irq0), 0);
    rd(0, 0, 1, v); chk("R9 status kept", v & 1, 1);
    pinIn[0] = 1'b0; ack(0, 0); waitc(1); chk("R9 cleared", int'(irq0), 0);

    // R11 latency of an edge
    wr(0, 1, 0, 15); ack(0, 1); waitc(2);
    pinIn[1] = 1'b1;
    waitc(2); rd(0, 1, 1, v); chk("R11 not yet at second edge", v & 1, 0);
    waitc(1); rd(0, 1, 1, v); chk("R11 set at third edge", v & 1, 1);

    // R7 acknowledge and event in the same cycle
    wr(0, 2, 0, 15); ack(0, 2); waitc(2);
    pinIn[2] = 1'b1;
    waitc(2);
    addr = {2'd2, 2'd1}; wrData = 5'd1; wrEn0 = 1'b1;
    @(negedge clk); wrEn0 = 1'b0;
    rd(0, 2, 1, v); chk("R7 event wins", v & 1, 1);
    ack(0, 2); rd(0, 2, 1, v); chk("R7 later ack clears", v & 1, 0);

    // R8 raw-status enable gating and re-enable
    wr(0, 3, 0, 13); ack(0, 3); waitc(2);
    pinIn[3] = 1'b1; waitc(5);
    rd(0, 3, 1, v); chk("R8 gated", v & 1, 0);
    pinIn[3] = 1'b0; waitc(5);
    wr(0, 3, 0, 15); waitc(3);
    rd(0, 3, 1, v); chk("R8 re-enable no latch", v & 1, 0);
    pinIn[3] = 1'b1; waitc(5);
    rd(0, 3, 1, v); chk("R8 latches again", v & 1, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule